// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single requests from a 16-bit processor core into bus cycles on an external memory bus. The bus shares the same lines for address and data. A request carries an address, write data, a byte or word size, a read/write flag and a flag that marks the access as internal. The block answers with a one-cycle `done` pulse. On a read, the assembled data comes with that pulse.

Each bus cycle runs through the same phases. First comes an address phase, in which an address-latch strobe is high and both byte lanes drive address bits. Then comes a strobe phase, in which the read strobe or one or both write strobes are low. Last comes an end phase.

A static `bus_narrow` input selects a 16-bit or an 8-bit data path. The `nowait` input, when low, adds one strobe cycle. A low ready input stretches the strobe phase. A low hold input parks the block once the current access ends, and the block signals this on `hlda_n`. In 8-bit mode, a word access is split into two byte cycles. The same split applies to a word at an odd address in 16-bit mode.

Top module: `mux_bus_ctrl`

## Requirements
- R1: With `bus_narrow` low, a word access at an even address is one bus cycle. The low lane carries data bits 7..0 and the high lane carries data bits 15..8. In a 16-bit read strobe phase, neither lane is driven.
- R2: In 8-bit mode, the high lane drives address bits 15..8 through the whole strobe phase, never data. All data moves on the low lane.
- R3: In 16-bit mode, a byte write to an even address pulls `wel_n` low, with data on the low lane. A byte write to an odd address pulls `weh_n` low, with data on the high lane. An aligned word write pulls both strobes low.
- R4: In 8-bit mode, every write strobe phase pulls `wel_n` low, and `weh_n` stays high.
- R5: `rd_n` is low in every strobe cycle of a read and in no cycle of a write. A byte read returns its byte in `rdata[7:0]`, with `rdata[15:8]` zero.
- R6: Every bus cycle starts with exactly one cycle of `ale` high. In that cycle `lo_out` is address bits 7..0, `hi_out` is bits 15..8, `addr_up` is the bits above, and both lanes are driven. The strobe phase follows at once. With no wait and no stall, `done` rises in the third cycle after the request is accepted.
- R7: A low `rdy_n` sampled at the end of the strobe phase keeps the strobe active for one more cycle. Each low sample adds one cycle.
- R8: A low `hold_n` while idle, or at the end of an access, puts the block into hold in the next cycle. In hold, `hlda_n` and `req_ready` are low and no strobe, `ale` or lane is driven. An access already under way completes first. Raising `hold_n` leaves hold in the next cycle.
- R9: With `nowait` low, every bus cycle has two strobe cycles instead of one.
- R10: An access flagged internal uses the 16-bit width, whatever level `bus_narrow` has.
- R11: A word access in 8-bit mode, or at an odd address in 16-bit mode, runs as two byte cycles. The first is at the given address with data bits 7..0. The second is at the address plus one with data bits 15..8. A read assembles the two bytes in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_narrow | input | 1 | 1 selects the 8-bit external data path (static) |
| nowait | input | 1 | 0 adds one strobe cycle per bus cycle |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 16 | Write data; byte accesses use bits 7..0 |
| req_word | input | 1 | 1 selects a word access, 0 a byte access |
| req_write | input | 1 | 1 selects a write, 0 a read |
| req_internal | input | 1 | Marks the access as internal (forces 16-bit width) |
| done | output | 1 | One-cycle pulse when the access ends |
| rdata | output | 16 | Read data, valid with `done` |
| ale | output | 1 | Address-latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wel_n | output | 1 | Low-byte write strobe, active low |
| weh_n | output | 1 | High-byte write strobe, active low |
| addr_up | output | ADDR_W-16 | Upper address bits |
| lo_out | output | 8 | Low lane output value |
| lo_oe | output | 1 | Low lane output enable |
| lo_in | input | 8 | Low lane input value |
| hi_out | output | 8 | High lane output value |
| hi_oe | output | 1 | High lane output enable |
| hi_in | input | 8 | High lane input value |
| rdy_n | input | 1 | Ready, active low stretches the strobe phase |
| hold_n | input | 1 | Hold request, active low |
| hlda_n | output | 1 | Hold acknowledge, active low |

## Verification
Properties check the following on every cycle:
- Read and write strobes never overlap.
- `weh_n` stays high during a narrow external access.
- Every `ale` cycle is followed directly by an active strobe.
- A low ready sample keeps the strobes unchanged for another cycle.
- `nowait` low always leads into the wait cycle.
- The hold state is silent on every output, and idle with a hold request always leads to acknowledge.

Only the bench's scenarios show the rest:
- which lane carries which byte;
- which strobe a given address and width select;
- the exact cycle count of each combination of width, wait, size and alignment;
- the order and assembly of split words;
- that an access under way finishes before hold is taken.

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_narrow,
  input  logic              nowait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic              req_word,
  input  logic              req_write,
  input  logic              req_internal,
  output logic              done,
  output logic [15:0]       rdata,
  output logic              ale,
  output logic              rd_n,
  output logic              wel_n,
  output logic              weh_n,
  output logic [ADDR_W-17:0] addr_up,
  output logic [7:0]        lo_out,
  output logic              lo_oe,
  input  logic [7:0]        lo_in,
  output logic [7:0]        hi_out,
  output logic              hi_oe,
  input  logic [7:0]        hi_in,
  input  logic              rdy_n,
  input  logic              hold_n,
  output logic              hlda_n
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WT, S_STRB, S_FIN, S_HOLD} st_t;
  st_t state;

  logic [ADDR_W-1:0] r_addr;
  logic [15:0]       r_wdata;
  logic              r_word, r_wr, r_int, second;

  wire              wide      = !bus_narrow || r_int;
  wire              word_cyc  = r_word && wide && !r_addr[0];
  wire              split     = r_word && !word_cyc;
  wire              last      = !split || second;
  wire [ADDR_W-1:0] cur_addr  = r_addr + ADDR_W'(second);
  wire [7:0]        bdat      = second ? r_wdata[15:8] : r_wdata[7:0];
  wire              strobe_ph = (state == S_WT) || (state == S_STRB);
  wire              use_lo    = !wide || word_cyc || !cur_addr[0];
  wire              use_hi    = wide && (word_cyc || cur_addr[0]);
  wire              addr_ph   = (state == S_ADDR);
  wire [7:0]        rbyte     = (wide && cur_addr[0]) ? hi_in : lo_in;

  assign req_ready = (state == S_IDLE) && hold_n;
  assign done      = (state == S_FIN) && last;
  assign hlda_n    = (state != S_HOLD);
  assign ale       = addr_ph;
  assign rd_n      = !(strobe_ph && !r_wr);
  assign wel_n     = !(strobe_ph && r_wr && use_lo);
  assign weh_n     = !(strobe_ph && r_wr && use_hi);
  assign addr_up   = cur_addr[ADDR_W-1:16];

  assign lo_out = addr_ph ? cur_addr[7:0] : (word_cyc ? r_wdata[7:0] : bdat);
  assign hi_out = (addr_ph || !wide) ? cur_addr[15:8] :
                  (word_cyc ? r_wdata[15:8] : bdat);
  assign lo_oe  = addr_ph || (strobe_ph && r_wr && use_lo);
  assign hi_oe  = addr_ph || (strobe_ph && (!wide || (r_wr && use_hi)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      r_addr  <= '0;
      r_wdata <= '0;
      r_word  <= 1'b0;
      r_wr    <= 1'b0;
      r_int   <= 1'b0;
      second  <= 1'b0;
      rdata   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (!hold_n) state <= S_HOLD;
          else if (req_valid) begin
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
            r_word  <= req_word;
            r_wr    <= req_write;
            r_int   <= req_internal;
            second  <= 1'b0;
            rdata   <= '0;
            state   <= S_ADDR;
          end
        end
        S_ADDR: state <= nowait ? S_STRB : S_WT;
        S_WT:   state <= S_STRB;
        S_STRB: begin
          if (rdy_n) begin
            if (!r_wr) begin
              if (word_cyc)    rdata <= {hi_in, lo_in};
              else if (second) rdata[15:8] <= rbyte;
              else             rdata[7:0]  <= rbyte;
            end
            state <= S_FIN;
          end
        end
        S_FIN: begin
          if (!last) begin
            second <= 1'b1;
            state  <= S_ADDR;
          end else begin
            state <= hold_n ? S_IDLE : S_HOLD;
          end
        end
        S_HOLD:  if (hold_n) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_narrow_weh_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_narrow && !r_int && state != S_IDLE && state != S_HOLD) |-> weh_n);

  assert_rd_we_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n || (wel_n && weh_n));

  assert_ale_then_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && (!rd_n || !wel_n || !weh_n)));

  assert_rdy_stretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STRB && !rdy_n) |=> (state == S_STRB && $stable({rd_n, wel_n, weh_n})));

  assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hlda_n |-> (!ale && rd_n && wel_n && weh_n && !lo_oe && !hi_oe && !req_ready));

  assert_hold_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !hold_n) |=> !hlda_n);

  assert_wait_inserted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && !nowait) |=> (state == S_WT));

endmodule

// File: tb/mux_bus_ctrl_tb.sv
module mux_bus_ctrl_tb_top;
  localparam int AW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_narrow = 1'b0, nowait = 1'b1;
  logic req_valid = 1'b0, req_word = 1'b0, req_write = 1'b0, req_internal = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic rdy_n = 1'b1, hold_n = 1'b1;
  logic req_ready, done, ale, rd_n, wel_n, weh_n, lo_oe, hi_oe, hlda_n;
  logic [15:0] rdata;
  logic [AW-17:0] addr_up;
  logic [7:0] lo_out, hi_out, lo_in, hi_in;

  int compared = 0, mismatched = 0;
  logic [AW-1:0] lat = '0;
  logic wide_m = 1'b1;

  always #10 clk = ~clk;

  mux_bus_ctrl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_narrow(bus_narrow), .nowait(nowait),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_word(req_word), .req_write(req_write),
    .req_internal(req_internal), .done(done), .rdata(rdata), .ale(ale),
    .rd_n(rd_n), .wel_n(wel_n), .weh_n(weh_n), .addr_up(addr_up),
    .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in), .hi_out(hi_out),
    .hi_oe(hi_oe), .hi_in(hi_in), .rdy_n(rdy_n), .hold_n(hold_n), .hlda_n(hlda_n)
  );

  function automatic logic [7:0] mval(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (ale) lat <= {addr_up, hi_out, lo_out};
  assign lo_in = wide_m ? mval({lat[AW-1:1], 1'b0}) : mval(lat);
  assign hi_in = mval({lat[AW-1:1], 1'b1});

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_access(input logic [AW-1:0] a, input logic [15:0] wd, input bit word,
                            input bit wr, input bit intl, input bit nar, input bit nw, input int stall);
    bit wide = !nar || intl;
    bit wcyc = word && wide && !a[0];
    int ncyc = (word && !wcyc) ? 2 : 1;
    int w = nw ? 0 : 1;
    int cyc = 1, ale_cnt = 0, adr_err = 0, stb_cnt = 0, stb_err = 0, lane_err = 0, rd_err = 0;
    int k = 0, kc = 0, left = stall;
    logic [15:0] got = '0;
    bit seen = 0;
    string stag, ctag;
    logic [15:0] exp_rd;
    @(negedge clk);
    bus_narrow = nar; nowait = nw; wide_m = wide;
    req_addr = a; req_wdata = wd; req_word = word; req_write = wr; req_internal = intl;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (cyc < 60) begin
      if (ale) begin
        logic [AW-1:0] ea = a + AW'(k);
        ale_cnt++;
        if ({addr_up, hi_out, lo_out} != ea || !lo_oe || !hi_oe) adr_err++;
        kc = k; k++;
      end
      if (!rd_n || !wel_n || !weh_n) begin
        logic [AW-1:0] ca = a + AW'(kc);
        logic [7:0] bd = (kc != 0) ? wd[15:8] : wd[7:0];
        bit el = wr && (!wide || wcyc || !ca[0]);
        bit eh = wr && wide && (wcyc || ca[0]);
        stb_cnt++;
        if (wel_n != !el || weh_n != !eh) stb_err++;
        if (rd_n != wr) rd_err++;
        if (el && (!lo_oe || lo_out != (wcyc ? wd[7:0] : bd))) lane_err++;
        if (eh && (!hi_oe || hi_out != (wcyc ? wd[15:8] : bd))) lane_err++;
        if (!wide && (!hi_oe || hi_out != ca[15:8])) lane_err++;
        if (wide && !wr && (lo_oe || hi_oe)) lane_err++;
        if (left > 0) begin rdy_n = 1'b0; left--; end else rdy_n = 1'b1;
      end else rdy_n = 1'b1;
      if (done) begin seen = 1; got = rdata; break; end
      @(negedge clk);
      cyc++;
    end
    rdy_n = 1'b1;
    ctag = (stall > 0) ? "R7" : (nw ? "R6" : "R9");
    stag = (intl && nar) ? "R10" : (nar ? "R4" : "R3");
    check(seen && cyc == ncyc * (3 + w) + stall, ctag, cyc, ncyc * (3 + w) + stall);
    check(stb_cnt == ncyc * (1 + w) + stall, ctag, stb_cnt, ncyc * (1 + w) + stall);
    check(ale_cnt == ncyc && adr_err == 0, (ncyc == 2) ? "R11" : "R6", ale_cnt * 256 + adr_err, ncyc * 256);
    check(stb_err == 0, stag, stb_err, 0);
    check(lane_err == 0, wide ? "R1" : "R2", lane_err, 0);
    check(rd_err == 0, "R5", rd_err, 0);
    if (!wr) begin
      exp_rd = word ? {mval(a + AW'(1)), mval(a)} : {8'h00, mval(a)};
      check(got == exp_rd, (ncyc == 2) ? "R11" : "R5", got, exp_rd);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL R6 watchdog act=%0h exp=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check({ale, rd_n, wel_n, weh_n, lo_oe, hi_oe, hlda_n, req_ready, done} == 9'b0_111_00_1_1_0,
          "R6", {ale, rd_n, wel_n, weh_n, lo_oe, hi_oe, hlda_n, req_ready, done}, 9'b0_111_00_1_1_0);

    for (int idx = 0; idx < 64; idx++) begin
      logic [AW-1:0] base = (AW'(18'h12340) + AW'(idx) * AW'(18'h01F3A)) & ~AW'(1);
      logic [AW-1:0] ad = idx[0] ? (base | AW'(1)) : base;
      run_access(ad, 16'hA55A ^ (16'(idx) * 16'h1357), idx[1], idx[2], idx[3], idx[4], idx[5], 0);
    end

    run_access(18'h2_0810, 16'hBEEF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1);
    run_access(18'h1_0457, 16'hC0DE, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3);
    run_access(18'h0_1120, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2);

    // R8: hold from idle
    @(negedge clk) hold_n = 1'b0;
    @(negedge clk);
    check(!hlda_n && !req_ready, "R8", {hlda_n, req_ready}, 2'b00);
    begin
      int bad = 0;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (ale || !rd_n || !wel_n || !weh_n || lo_oe || hi_oe || hlda_n) bad++;
      end
      check(bad == 0, "R8", bad, 0);
    end
    hold_n = 1'b1;
    @(negedge clk);
    check(hlda_n && req_ready, "R8", {hlda_n, req_ready}, 2'b11);
    run_access(18'h0_0044, 16'h00AB, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 0);

    // R8: hold raised during an access, access completes first
    @(negedge clk);
    bus_narrow = 1'b0; nowait = 1'b1; wide_m = 1'b1;
    req_addr = 18'h0_0200; req_wdata = 16'h5566; req_word = 1'b0; req_write = 1'b1; req_internal = 1'b0;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    hold_n = 1'b0;
    check(ale && hlda_n, "R8", {ale, hlda_n}, 2'b11);
    @(negedge clk);
    check(!wel_n && hlda_n, "R8", {wel_n, hlda_n}, 2'b01);
    @(negedge clk);
    check(done && hlda_n, "R8", {done, hlda_n}, 2'b11);
    @(negedge clk);
    check(!hlda_n && !req_ready, "R8", {hlda_n, req_ready}, 2'b00);
    hold_n = 1'b1;
    @(negedge clk);
    check(hlda_n, "R8", hlda_n, 1);

    summary();
    $finish;
  end
endmodule